// File: doc/BRIEF.md
# Reset Source Controller

This block merges every reset request of a small controller into a single system reset and keeps a set of sticky cause flags that tell software which event produced the last reset. The requests come from several places. Supply supervision provides a supply-good level and three voltage-monitor trip levels. The external reset pin is active low. Two watchdogs provide event pulses. Memory and bus protection logic provide error pulses, and software can issue a reset request. The supply-good level, the trip levels and the pin are asynchronous to the clock. Every other input is a synchronous single-cycle pulse.

Each watchdog has a select bit. With the bit clear, a watchdog event becomes a short timed reset and sets that watchdog's flag. With the bit set, the event becomes a one-cycle non-maskable interrupt pulse and produces no reset. The power-on flag behaves differently from the other flags. A pin reset clears it. No other reset and no software write can change it. All other flags are cleared by writing 1 to them, and they survive resets they did not cause.

`rst_ni` is the register initialisation from the power-up cell. It asserts the system reset asynchronously and loads the flags with only the power-on bit set.

Top module: `rst_src_ctrl`

## Requirements
- R1: While the synchronised supply-good input is low and the synchronised pin is high, the system reset is asserted and cause bit 0 (power-on) is set.
- R2: After supply-good returns high, the power-on reset stays asserted for at least POR_CYC clock cycles and then releases. A supply drop during that count restarts it from zero.
- R3: Cause bit 0 ignores software writes and resets from every other source, and a pin low pulse too short to be accepted leaves it unchanged. An accepted pin reset clears it to 0.
- R4: A pin low pulse shorter than PIN_MIN synchronised cycles causes no reset. A longer one holds the system reset for as long as the pin stays low.
- R5: A watchdog event with its select bit at 1 produces exactly one cycle of nmi_o, no reset and no flag.
- R6: A watchdog event with its select bit at 0 produces a reset of exactly WD_CYC cycles and sets cause bit 1 for watchdog 0 or cause bit 2 for watchdog 1.
- R7: Voltage monitor k (k = 0..2) holds the system reset while its trip input is high and sets cause bit 3+k.
- R8: A parity, ECC, bus master, bus slave, stack pointer or software pulse produces a reset of exactly RST_CYC cycles and sets cause bit 6, 7, 8, 9, 10 or 11 respectively.
- R9: Writing a 1 to any of cause bits 1..11 clears that bit. Bits that were not written stay set across later resets.
- R10: When reset sources overlap, the system reset stays asserted until the last one has released.
- R11: With EN_ECC = 0, an ECC pulse causes no reset and cause bit 7 always reads 0.
- R12: Asserting rst_ni asserts sys_rst_o without waiting for a clock edge and loads the cause flags with 12'h001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-up register initialisation, active low, asynchronous |
| rst_pin_ni | input | 1 | External reset pin, active low, asynchronous |
| vcc_ok_i | input | 1 | Supply above power-on threshold, asynchronous |
| lvd_trip_i | input | 3 | Voltage monitor trips, 1 = supply below level, asynchronous |
| wdt_evt_i | input | 2 | Watchdog underflow or refresh-error pulses |
| wdt_nmi_sel_i | input | 2 | Per-watchdog select: 1 = NMI, 0 = reset |
| par_err_i | input | 1 | SRAM parity error pulse |
| ecc_err_i | input | 1 | SRAM ECC error pulse |
| bus_mst_err_i | input | 1 | Bus master protection error pulse |
| bus_slv_err_i | input | 1 | Bus slave protection error pulse |
| sp_err_i | input | 1 | Stack pointer error pulse |
| sw_rst_i | input | 1 | Software reset request pulse |
| reg_wr_i | input | 1 | Cause register write strobe |
| reg_wdata_i | input | 12 | Write data, 1 clears the matching flag |
| sys_rst_o | output | 1 | System reset, active high |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| cause_o | output | 12 | Sticky reset cause flags |

## Verification
The assertions assume that the synchronous error, software and watchdog inputs are pulses aligned to the clock. They also assume that a pin reset and a power-on condition never start in the same cycle, which the synchroniser ordering ensures. The bench drives every pulse input for exactly one cycle from the falling clock edge. It keeps the asynchronous levels stable for many cycles, so each synchronised transition is seen cleanly. Random runs pick one source at a time with random gaps and random clear masks. Directed cases cover overlap, supply drops and short pin pulses.

// File: rtl/rst_src_pkg.sv
`timescale 1ns/1ps
package rst_src_pkg;
  localparam int NUM_FLAGS = 12;
  localparam int NUM_LVD   = 3;
  localparam int NUM_WDT   = 2;
  localparam int NUM_STR   = 8;  // stretched pulse sources
  localparam int IDX_POR   = 0;
  localparam int IDX_WD0   = 1;
  localparam int IDX_LVD0  = 3;
  localparam int IDX_PAR   = 6;
  localparam int IDX_ECC   = 7;
  localparam logic [NUM_FLAGS-1:0] POR_MASK = NUM_FLAGS'(1) << IDX_POR;
  typedef logic [NUM_FLAGS-1:0] cause_t;
endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/rst_stretch.sv
`timescale 1ns/1ps
module rst_stretch #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic act_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (trig_i)            cnt_q <= CW'(CYC);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end
  assign act_o = (cnt_q != '0);
endmodule

// File: rtl/rst_por_ctl.sv
`timescale 1ns/1ps
module rst_por_ctl #(
  parameter int POR_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic pin_hi_i,
  output logic act_o,
  output logic start_o
);
  localparam int CW = $clog2(POR_CYC + 1);
  logic [CW-1:0] cnt_q;
  logic          act_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (!vcc_ok_i) begin
      cnt_q <= '0;  // supply drop restarts the stabilisation count
      if (pin_hi_i) act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == CW'(POR_CYC - 1)) act_q <= 1'b0;
      else                           cnt_q <= cnt_q + 1'b1;
    end
  end
  assign act_o   = act_q;
  assign start_o = !act_q && !vcc_ok_i && pin_hi_i;
endmodule

// File: rtl/rst_pin_filt.sv
`timescale 1ns/1ps
module rst_pin_filt #(
  parameter int PIN_MIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_hi_i,
  output logic act_o
);
  localparam int CW = $clog2(PIN_MIN + 1);
  logic [CW-1:0] cnt_q;
  logic          act_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (pin_hi_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!act_q) begin
      if (cnt_q == CW'(PIN_MIN - 1)) act_q <= 1'b1;
      else                           cnt_q <= cnt_q + 1'b1;
    end
  end
  assign act_o = act_q;
endmodule

// File: rtl/rst_src_ctrl.sv
`timescale 1ns/1ps
module rst_src_ctrl
  import rst_src_pkg::*;
#(
  parameter int POR_CYC = 64,
  parameter int PIN_MIN = 4,
  parameter int RST_CYC = 16,
  parameter int WD_CYC  = 8,
  parameter bit EN_ECC  = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rst_pin_ni,
  input  logic                 vcc_ok_i,
  input  logic [NUM_LVD-1:0]   lvd_trip_i,
  input  logic [NUM_WDT-1:0]   wdt_evt_i,
  input  logic [NUM_WDT-1:0]   wdt_nmi_sel_i,
  input  logic                 par_err_i,
  input  logic                 ecc_err_i,
  input  logic                 bus_mst_err_i,
  input  logic                 bus_slv_err_i,
  input  logic                 sp_err_i,
  input  logic                 sw_rst_i,
  input  logic                 reg_wr_i,
  input  logic [NUM_FLAGS-1:0] reg_wdata_i,
  output logic                 sys_rst_o,
  output logic                 nmi_o,
  output logic [NUM_FLAGS-1:0] cause_o
);
  localparam int SW = NUM_LVD + 2;

  logic [SW-1:0]      async_s;
  logic               pin_hi, vcc_ok;
  logic [NUM_LVD-1:0] lvd_s;
  logic               por_act, por_start, pin_act;
  logic               ecc_g;
  logic [NUM_STR-1:0] str_trig, str_act;
  cause_t             set_v, cause_q, cause_d;
  logic               nmi_q, sys_rst_q;

  rst_sync #(.W(SW), .RST_VAL({1'b1, 1'b0, {NUM_LVD{1'b0}}})) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rst_pin_ni, vcc_ok_i, lvd_trip_i}),
    .q_o   (async_s)
  );
  assign pin_hi = async_s[SW-1];
  assign vcc_ok = async_s[SW-2];
  assign lvd_s  = async_s[NUM_LVD-1:0];

  rst_por_ctl #(.POR_CYC(POR_CYC)) u_por (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vcc_ok_i(vcc_ok),
    .pin_hi_i(pin_hi),
    .act_o   (por_act),
    .start_o (por_start)
  );

  rst_pin_filt #(.PIN_MIN(PIN_MIN)) u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_hi_i(pin_hi),
    .act_o   (pin_act)
  );

  if (EN_ECC) begin : g_ecc_on
    assign ecc_g = ecc_err_i;
  end else begin : g_ecc_off
    assign ecc_g = 1'b0;
  end

  // stretched sources: watchdogs first, then flag order PAR..SW
  assign str_trig = {sw_rst_i, sp_err_i, bus_slv_err_i, bus_mst_err_i, ecc_g, par_err_i,
                     wdt_evt_i & ~wdt_nmi_sel_i};

  for (genvar j = 0; j < NUM_STR; j++) begin : g_str
    localparam int CYC  = (j < NUM_WDT) ? WD_CYC : RST_CYC;
    localparam int FIDX = (j < NUM_WDT) ? IDX_WD0 + j : IDX_PAR + j - NUM_WDT;
    rst_stretch #(.CYC(CYC)) u_str (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .trig_i(str_trig[j]),
      .act_o (str_act[j])
    );
    assign set_v[FIDX] = str_trig[j];
  end
  for (genvar k = 0; k < NUM_LVD; k++) begin : g_lvd
    assign set_v[IDX_LVD0 + k] = lvd_s[k];
  end
  assign set_v[IDX_POR] = por_start;

  always_comb begin
    cause_d = cause_q;
    if (reg_wr_i) cause_d = cause_d & ~(reg_wdata_i & ~POR_MASK);
    cause_d = cause_d | set_v;
    if (pin_act) cause_d[IDX_POR] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q   <= POR_MASK;
      nmi_q     <= 1'b0;
      sys_rst_q <= 1'b1;
    end else begin
      cause_q   <= cause_d;
      nmi_q     <= |(wdt_evt_i & wdt_nmi_sel_i);
      sys_rst_q <= por_act | pin_act | (|lvd_s) | (|str_act);
    end
  end

  assign sys_rst_o = sys_rst_q;
  assign nmi_o     = nmi_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/rst_src_ctrl_chk.sv
`timescale 1ns/1ps
module rst_src_ctrl_chk
  import rst_src_pkg::*;
#(
  parameter bit EN_ECC = 1'b1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sys_rst_o,
  input logic                 nmi_o,
  input logic [NUM_FLAGS-1:0] cause_o,
  input logic [NUM_WDT-1:0]   wdt_evt_i,
  input logic [NUM_WDT-1:0]   wdt_nmi_sel_i,
  input logic                 sw_rst_i,
  input logic                 reg_wr_i,
  input logic [NUM_FLAGS-1:0] reg_wdata_i,
  input logic                 por_act_i,
  input logic                 pin_act_i
);
  AST_POR_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_act_i |=> sys_rst_o); // R1

  AST_PIN_CLEARS_POR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act_i |=> !cause_o[IDX_POR]); // R3

  AST_PIN_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act_i |=> sys_rst_o); // R4

  AST_NMI_FROM_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> $past(|(wdt_evt_i & wdt_nmi_sel_i))); // R5

  AST_SW_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |-> ##2 sys_rst_o); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cause_o) & ~cause_o & ~POR_MASK &
      ~($past(reg_wr_i) ? $past(reg_wdata_i) : '0)) == '0)); // R9

  if (!EN_ECC) begin : g_ecc_off
    AST_ECC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cause_o[IDX_ECC]); // R11
  end
endmodule

bind rst_src_ctrl rst_src_ctrl_chk #(.EN_ECC(EN_ECC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_rst_o    (sys_rst_o),
  .nmi_o        (nmi_o),
  .cause_o      (cause_o),
  .wdt_evt_i    (wdt_evt_i),
  .wdt_nmi_sel_i(wdt_nmi_sel_i),
  .sw_rst_i     (sw_rst_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .por_act_i    (por_act),
  .pin_act_i    (pin_act)
);

// File: tb/sim_rst_src_ctrl.sv
`timescale 1ns/1ps
module sim_rst_src_ctrl;
  localparam int POR_CYC = 64;
  localparam int PIN_MIN = 4;
  localparam int RST_CYC = 16;
  localparam int WD_CYC  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic rst_pin_ni = 1'b1;
  logic vcc_ok = 1'b0;
  logic [2:0] lvd = '0;
  logic [1:0] wdt_evt = '0, wdt_sel = '0;
  logic par = 0, ecc = 0, bmst = 0, bslv = 0, sp = 0, sw = 0;
  logic reg_wr = 0;
  logic [11:0] wdata = '0;
  logic sys_rst, nmi, sys_rst1, nmi1;
  logic [11:0] cause, cause1;
  int errors = 0, checks = 0;
  logic [11:0] model;

  always #2.5 clk = ~clk;

  rst_src_ctrl #(.POR_CYC(POR_CYC), .PIN_MIN(PIN_MIN), .RST_CYC(RST_CYC), .WD_CYC(WD_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_ni(rst_pin_ni), .vcc_ok_i(vcc_ok), .lvd_trip_i(lvd),
    .wdt_evt_i(wdt_evt), .wdt_nmi_sel_i(wdt_sel), .par_err_i(par), .ecc_err_i(ecc),
    .bus_mst_err_i(bmst), .bus_slv_err_i(bslv), .sp_err_i(sp), .sw_rst_i(sw),
    .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .sys_rst_o(sys_rst), .nmi_o(nmi), .cause_o(cause));

  rst_src_ctrl #(.POR_CYC(POR_CYC), .PIN_MIN(PIN_MIN), .RST_CYC(RST_CYC), .WD_CYC(WD_CYC),
                 .EN_ECC(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_ni(rst_pin_ni), .vcc_ok_i(vcc_ok), .lvd_trip_i(lvd),
    .wdt_evt_i(wdt_evt), .wdt_nmi_sel_i(wdt_sel), .par_err_i(par), .ecc_err_i(ecc),
    .bus_mst_err_i(bmst), .bus_slv_err_i(bslv), .sp_err_i(sp), .sw_rst_i(sw),
    .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .sys_rst_o(sys_rst1), .nmi_o(nmi1), .cause_o(cause1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int fidx(input int src);
    return (src < 2) ? 1 + src : 6 + src - 2;
  endfunction

  function automatic int exp_dur(input int src, input bit sel);
    if (src < 2) return sel ? 0 : WD_CYC;
    return RST_CYC;
  endfunction

  task automatic drive_src(input int src, input bit v);
    case (src)
      0: wdt_evt[0] = v;
      1: wdt_evt[1] = v;
      2: par = v;
      3: ecc = v;
      4: bmst = v;
      5: bslv = v;
      6: sp = v;
      default: sw = v;
    endcase
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic w1c(input logic [11:0] m);
    wdata = m; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; wdata = '0;
    model = model & ~(m & 12'hffe);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rst_cnt, nmi_cnt;
    void'($urandom(32'd1234));
    #1 rst_ni = 1'b0;
    #1;
    chk(sys_rst === 1'b1, "R12 async reset", sys_rst, 1);
    chk(cause === 12'h001, "R12 reset flags", cause, 12'h001);
    wcyc(3);
    rst_ni = 1'b1;
    model = 12'h001;
    wcyc(6);
    chk(sys_rst === 1'b1, "R1 por held", sys_rst, 1);
    chk(cause === 12'h001, "R1 por flag", cause, 12'h001);
    w1c(12'hfff);
    wcyc(1);
    chk(cause === 12'h001, "R3 por flag ignores write", cause, 12'h001);

    vcc_ok = 1'b1;
    wcyc(POR_CYC / 2);
    vcc_ok = 1'b0;
    wcyc(3);
    vcc_ok = 1'b1;
    wcyc(POR_CYC - 1);
    chk(sys_rst === 1'b1, "R2 por restart still held", sys_rst, 1);
    wcyc(7);
    chk(sys_rst === 1'b0, "R2 por released", sys_rst, 0);

    // short pin pulse
    rst_pin_ni = 1'b0;
    wcyc(PIN_MIN - 2);
    rst_pin_ni = 1'b1;
    rst_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sys_rst) rst_cnt++;
    end
    chk(rst_cnt == 0, "R4 short pin ignored", rst_cnt, 0);
    chk(cause === model, "R3 short pin keeps por", cause, model);

    for (int k = 0; k < 3; k++) begin
      lvd[k] = 1'b1;
      wcyc(8);
      chk(sys_rst === 1'b1, "R7 lvd held", sys_rst, 1);
      lvd[k] = 1'b0;
      wcyc(5);
      chk(sys_rst === 1'b0, "R7 lvd released", sys_rst, 0);
      model[3 + k] = 1'b1;
      chk(cause === model, "R7 lvd flag", cause, model);
    end

    for (int it = 0; it < 40; it++) begin
      int src;
      bit sel;
      src = int'($urandom % 8);
      sel = 1'($urandom);
      wdt_sel = {sel, sel};
      drive_src(src, 1'b1);
      rst_cnt = 0; nmi_cnt = 0;
      for (int i = 1; i <= RST_CYC + 8; i++) begin
        @(negedge clk);
        if (i == 1) drive_src(src, 1'b0);
        if (sys_rst) rst_cnt++;
        if (nmi) nmi_cnt++;
      end
      if (src < 2) begin
        chk(rst_cnt == exp_dur(src, sel), sel ? "R5 nmi no reset" : "R6 wdt reset length",
            rst_cnt, exp_dur(src, sel));
        chk(nmi_cnt == int'(sel), "R5 nmi pulse count", nmi_cnt, int'(sel));
        if (!sel) model[fidx(src)] = 1'b1;
      end else begin
        chk(rst_cnt == exp_dur(src, sel), "R8 source reset length", rst_cnt, exp_dur(src, sel));
        model[fidx(src)] = 1'b1;
      end
      chk(cause === model, "R6 R8 cause flags", cause, model);
      if ($urandom % 2 == 1) begin
        w1c(12'($urandom));
        wcyc(1);
        chk(cause === model, "R9 w1c result", cause, model);
      end
      wcyc(int'($urandom % 4));
    end
    wdt_sel = '0;

    // overlap
    sw = 1'b1;
    rst_cnt = 0;
    for (int i = 1; i <= RST_CYC + 12; i++) begin
      @(negedge clk);
      if (sys_rst) rst_cnt++;
      if (i == 1) sw = 1'b0;
      if (i == 5) par = 1'b1;
      if (i == 6) par = 1'b0;
    end
    chk(rst_cnt == RST_CYC + 5, "R10 overlap length", rst_cnt, RST_CYC + 5);
    model[11] = 1'b1; model[6] = 1'b1;
    chk(cause === model, "R9 flags sticky across resets", cause, model);

    // ECC disabled instance
    w1c(12'hffe);
    ecc = 1'b1;
    rst_cnt = 0;
    for (int i = 1; i <= RST_CYC + 4; i++) begin
      @(negedge clk);
      if (i == 1) ecc = 1'b0;
      if (sys_rst1) rst_cnt++;
    end
    chk(rst_cnt == 0, "R11 ecc off no reset", rst_cnt, 0);
    chk(cause1[7] === 1'b0, "R11 ecc off flag", cause1[7], 0);
    model[7] = 1'b1;
    chk(cause === model, "R8 ecc on flag", cause, model);

    // long pin pulse
    rst_pin_ni = 1'b0;
    wcyc(12);
    chk(sys_rst === 1'b1, "R4 pin held", sys_rst, 1);
    rst_pin_ni = 1'b1;
    wcyc(6);
    chk(sys_rst === 1'b0, "R4 pin released", sys_rst, 0);
    model[0] = 1'b0;
    chk(cause === model, "R3 pin clears por", cause, model);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule